// File: doc/BRIEF.md
# Line Scan Framing and Pixel Handoff Controller

This block frames the line scans of a linear image sensor front end and hands each converted pixel to a host. It runs in one of two framing modes, chosen by a level input. In externally framed mode, a rising edge on the sync input starts a line, and a low level on it ends the line. In self-framed mode, a run input starts a series of lines. The block then drives its own sync output high for each line, lays down a programmable number of pixels, and drops sync again. It keeps sync low for a fixed guard gap between lines.

Within a line, every pixel period is four master-clock cycles. During that period the end-of-conversion strobe is low for two cycles and high for two. On the clock edge where the strobe falls, the pixel value from the converter is captured into an output latch. The host reads the latch by pulling the active-low pixel-read input low while sync is high. The 10-bit bus is modelled as a data vector plus an output-enable, and a pad ring outside the block would use them to drive a shared bus.

The controller is a four-state machine. The states are IDLE, LINE, DRAIN and GAP.
- **IDLE → LINE (start):** in self-framed mode this happens when run is high. In externally framed mode it happens on a rising sync edge.
- **LINE → LINE (next pixel):** taken at the end of a pixel period when the line continues.
- **LINE → GAP (line done):** taken at the end of the last pixel in self-framed mode. In externally framed mode it is taken when sync is already low at the end of a pixel period.
- **LINE → DRAIN (sync dropped):** taken in externally framed mode when sync falls in the middle of a pixel period.
- **DRAIN → GAP (pixel finished):** taken when that pixel period completes.
- **GAP → IDLE (gap expired):** taken after the guard-gap cycles have elapsed.

Top module: `line_scan_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, sync_o is 0, eoc_o is 1, bus_oe_o is 0 and bus_o is 0.
- R2: With sync_out_mode_i=0 and the block idle, a rising edge on sync_in_i starts a line. eoc_o is low in the first cycle after the edge that samples sync_in_i high.
- R3: In externally framed mode, once sync_in_i is low, the pixel in progress completes and its strobe rises within 8 cycles. No further strobe falls until a new line starts.
- R4: A rising edge of sync_in_i that arrives while a line is still finishing or the guard gap is running is ignored. A new line needs sync_in_i to go low and then rise again while the block is idle.
- R5: In externally framed mode, run_i has no effect and sync_o stays 0.
- R6: With sync_out_mode_i=1 and run_i high while idle, sync_o rises in the next cycle. A line then holds sync_o high for exactly 4·N cycles and produces exactly N strobe falls. N is pix_per_line_i as sampled at the line start, with 0 treated as 1. Changes to pix_per_line_i during a line do not affect that line.
- R7: If run_i goes low during a self-framed line, that line completes with its full pixel count, and no further line starts.
- R8: Between lines, sync_o stays low for at least GAP_CYC (8) cycles. If run_i is held high, the gap is exactly GAP_CYC+1 cycles.
- R9: Each strobe low pulse lasts exactly 2 cycles. Within a line, consecutive strobe falls are exactly 4 cycles apart. The strobe stays high when no line is active.
- R10: The output latch loads pix_data_i on the clock edge at which eoc_o falls. While sync is high, meaning sync_o in self-framed mode and sync_in_i in externally framed mode, and pix_rd_n_i is 0, bus_oe_o is 1 and bus_o equals the latch.
- R11: While sync is low, pix_rd_n_i is ignored: bus_oe_o is 0 and bus_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_out_mode_i | input | 1 | 1 = self-framed (drives sync_o), 0 = externally framed by sync_in_i; changed only while idle |
| run_i | input | 1 | Starts/stops a series of lines in self-framed mode |
| sync_in_i | input | 1 | External line frame in externally framed mode |
| pix_per_line_i | input | CNT_W (12) | Pixels per line in self-framed mode, 0 treated as 1 |
| pix_data_i | input | DW (10) | Converted pixel value from the converter |
| pix_rd_n_i | input | 1 | Active-low host pixel read |
| sync_o | output | 1 | Self-generated line frame |
| eoc_o | output | 1 | End-of-conversion strobe |
| bus_o | output | DW (10) | Pixel data toward the shared bus, 0 when not enabled |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
Two events can fall on the same cycle: the latch capture at a falling strobe and a host read with pix_rd_n_i held low. The bench randomises pix_rd_n_i and pix_data_i every cycle, so reads often straddle strobe falls. It expects the bus to show the newly captured value in the very cycle the strobe is seen low. The end of a line can also meet any pixel phase. Random line lengths in externally framed mode drop sync at every phase, and each time the bench expects the in-flight pixel to complete within the 8-cycle bound and no new strobe to follow.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINE  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_GAP   = 2'd3
    } lsc_state_e;

endpackage

// File: rtl/lsc_pixel_seq.sv
module lsc_pixel_seq #(
    parameter int CNT_W  = 12,
    parameter int EOC_LO = 2,
    parameter int EOC_HI = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             ph_last_o,
    output logic             pix_last_o,
    output logic             eoc_low_o
);

    localparam int PERIOD = EOC_LO + EOC_HI;
    localparam int PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] pix_cnt_q;
    logic [CNT_W-1:0] limit_q;

    assign ph_last_o  = (phase_q == PH_W'(PERIOD - 1));
    assign eoc_low_o  = (phase_q < PH_W'(EOC_LO));
    assign pix_last_o = (pix_cnt_q == (limit_q - CNT_W'(1)));

    // phase within a pixel period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (start_i) begin
            phase_q <= '0;
        end else if (active_i) begin
            phase_q <= ph_last_o ? '0 : phase_q + PH_W'(1);
        end
    end

    // pixel counter and per-line limit, limit frozen at line start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_cnt_q <= '0;
            limit_q   <= CNT_W'(1);
        end else if (start_i) begin
            pix_cnt_q <= '0;
            limit_q   <= (count_i == '0) ? CNT_W'(1) : count_i;
        end else if (active_i && ph_last_o) begin
            pix_cnt_q <= pix_cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lsc_gap_timer.sv
module lsc_gap_timer #(
    parameter int GAP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic done_o
);

    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] cnt_q;

    assign done_o = en_i && (cnt_q == GW'(GAP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + GW'(1);
        end
    end

endmodule

// File: rtl/lsc_fsm.sv
module lsc_fsm
    import lsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_mode_i,
    input  logic run_i,
    input  logic sync_rise_i,
    input  logic sync_lvl_i,
    input  logic ph_last_i,
    input  logic pix_last_i,
    input  logic gap_done_i,
    output logic px_start_o,
    output logic px_next_o,
    output logic active_o,
    output logic gap_en_o,
    output logic sync_drv_o
);

    lsc_state_e state_q;
    lsc_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (out_mode_i ? run_i : sync_rise_i) begin
                    state_d = ST_LINE;
                end
            end
            ST_LINE: begin
                if (out_mode_i) begin
                    if (ph_last_i && pix_last_i) begin
                        state_d = ST_GAP;
                    end
                end else if (!sync_lvl_i) begin
                    state_d = ph_last_i ? ST_GAP : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ph_last_i) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_done_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        px_start_o = (state_q == ST_IDLE) && (state_d == ST_LINE);
        px_next_o  = (state_q == ST_LINE) && ph_last_i && (state_d == ST_LINE);
        active_o   = (state_q == ST_LINE) || (state_q == ST_DRAIN);
        gap_en_o   = (state_q == ST_GAP);
        sync_drv_o = (state_q == ST_LINE) && out_mode_i;
    end

endmodule

// File: rtl/line_scan_ctrl.sv
module line_scan_ctrl #(
    parameter int DW      = 10,
    parameter int CNT_W   = 12,
    parameter int EOC_LO  = 2,
    parameter int EOC_HI  = 2,
    parameter int GAP_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_out_mode_i,
    input  logic             run_i,
    input  logic             sync_in_i,
    input  logic [CNT_W-1:0] pix_per_line_i,
    input  logic [DW-1:0]    pix_data_i,
    input  logic             pix_rd_n_i,
    output logic             sync_o,
    output logic             eoc_o,
    output logic [DW-1:0]    bus_o,
    output logic             bus_oe_o
);

    logic          sync_in_q;
    logic          sync_rise;
    logic          ph_last;
    logic          pix_last;
    logic          eoc_low;
    logic          gap_done;
    logic          px_start;
    logic          px_next;
    logic          active;
    logic          gap_en;
    logic          sync_drv;
    logic          sync_lvl;
    logic [DW-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_in_q <= 1'b0;
        end else begin
            sync_in_q <= sync_in_i;
        end
    end

    assign sync_rise = sync_in_i && !sync_in_q;

    lsc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_mode_i (sync_out_mode_i),
        .run_i      (run_i),
        .sync_rise_i(sync_rise),
        .sync_lvl_i (sync_in_i),
        .ph_last_i  (ph_last),
        .pix_last_i (pix_last),
        .gap_done_i (gap_done),
        .px_start_o (px_start),
        .px_next_o  (px_next),
        .active_o   (active),
        .gap_en_o   (gap_en),
        .sync_drv_o (sync_drv)
    );

    lsc_pixel_seq #(
        .CNT_W (CNT_W),
        .EOC_LO(EOC_LO),
        .EOC_HI(EOC_HI)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (px_start),
        .active_i  (active),
        .count_i   (pix_per_line_i),
        .ph_last_o (ph_last),
        .pix_last_o(pix_last),
        .eoc_low_o (eoc_low)
    );

    lsc_gap_timer #(
        .GAP_CYC(GAP_CYC)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (gap_en),
        .done_o(gap_done)
    );

    // capture on the edge where the strobe falls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (px_start || px_next) begin
            latch_q <= pix_data_i;
        end
    end

    assign sync_o   = sync_drv;
    assign eoc_o    = !(active && eoc_low);
    assign sync_lvl = sync_out_mode_i ? sync_drv : sync_in_i;
    assign bus_oe_o = sync_lvl && !pix_rd_n_i;
    assign bus_o    = bus_oe_o ? latch_q : '0;

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int DW      = 10,
    parameter int GAP_CYC = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_o,
    input logic          eoc_o,
    input logic          bus_oe_o,
    input logic [DW-1:0] bus_o
);

    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= GW'(GAP_CYC);
        end else if (sync_o) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q < GW'(GAP_CYC)) begin
            low_cnt_q <= low_cnt_q + GW'(1);
        end
    end

    p_eoc_low_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_o) |=> !eoc_o);

    p_eoc_low_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoc_o && $past(!eoc_o)) |=> eoc_o);

    p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> (low_cnt_q >= GW'(GAP_CYC)));

    p_latch_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o) && !$fell(eoc_o)) |-> $stable(bus_o));

endmodule

bind line_scan_ctrl lsc_checker #(
    .DW     (DW),
    .GAP_CYC(GAP_CYC)
) u_lsc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_o  (sync_o),
    .eoc_o   (eoc_o),
    .bus_oe_o(bus_oe_o),
    .bus_o   (bus_o)
);

// File: tb/tb_line_scan_ctrl.sv
module tb_line_scan_ctrl;

    localparam int DW    = 10;
    localparam int CNT_W = 12;
    localparam int GAP   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode = 1'b0;
    logic             run = 1'b0;
    logic             sync_in = 1'b0;
    logic [CNT_W-1:0] ppl = '0;
    logic [DW-1:0]    data = '0;
    logic             rd_n = 1'b1;
    logic             sync_o;
    logic             eoc_o;
    logic [DW-1:0]    bus_o;
    logic             bus_oe_o;

    int n_cmp = 0;
    int n_bad = 0;

    // monitor state
    bit          mon_en = 1'b0;
    logic        prev_eoc = 1'b1;
    logic        prev_sync = 1'b0;
    int          low_run = 0;
    int          hi_len = 0;
    int          falls_in_line = 0;
    int          n_exp = 1;
    int          sync_low_run = 100;
    int          cyc_since_fall = 100;
    int          lines_done = 0;
    bit          run_low_seen = 1'b1;
    logic [DW-1:0] latch_m = '0;

    always #4 clk = ~clk;

    line_scan_ctrl #(.DW(DW), .CNT_W(CNT_W), .GAP_CYC(GAP)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_out_mode_i(mode),
        .run_i          (run),
        .sync_in_i      (sync_in),
        .pix_per_line_i (ppl),
        .pix_data_i     (data),
        .pix_rd_n_i     (rd_n),
        .sync_o         (sync_o),
        .eoc_o          (eoc_o),
        .bus_o          (bus_o),
        .bus_oe_o       (bus_oe_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? 1 : int'(c);
    endfunction

    task automatic monitor();
        logic sl;
        if (!mon_en) return;
        cyc_since_fall++;
        if (!prev_sync && sync_o) begin
            if (lines_done > 0) begin
                if (!run_low_seen) chk(sync_low_run == GAP + 1, "R8", sync_low_run, GAP + 1);
                else               chk(sync_low_run >= GAP, "R8", sync_low_run, GAP);
            end
            n_exp = eff_count(ppl);
            hi_len = 0;
            falls_in_line = 0;
        end
        if (prev_sync && !sync_o) begin
            chk(hi_len == 4 * n_exp, "R6", hi_len, 4 * n_exp);
            chk(falls_in_line == n_exp, "R6", falls_in_line, n_exp);
            lines_done++;
            sync_low_run = 0;
            run_low_seen = 1'b0;
        end
        if (sync_o) hi_len++;
        else begin
            sync_low_run++;
            if (!run) run_low_seen = 1'b1;
        end
        if (prev_eoc && !eoc_o) begin
            latch_m = data;
            falls_in_line++;
            if (cyc_since_fall < 10) chk(cyc_since_fall == 4, "R9", cyc_since_fall, 4);
            cyc_since_fall = 0;
        end
        if (!eoc_o) low_run++;
        else begin
            if (!prev_eoc) chk(low_run == 2, "R9", low_run, 2);
            low_run = 0;
        end
        sl = mode ? sync_o : sync_in;
        if (sl && !rd_n) chk(bus_oe_o && bus_o == latch_m, "R10", bus_o, latch_m);
        else             chk(!bus_oe_o && bus_o == '0, "R11", {bus_oe_o, bus_o}, 0);
        prev_eoc = eoc_o;
        prev_sync = sync_o;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        monitor();
        data = DW'($urandom);
        rd_n = 1'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int snap;
        int guard;
        void'($urandom(32'd4242));

        // R1: reset values
        repeat (3) @(negedge clk);
        chk(sync_o == 0 && eoc_o == 1 && bus_oe_o == 0 && bus_o == 0, "R1",
            {sync_o, eoc_o, bus_oe_o}, 3'b010);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(sync_o == 0 && eoc_o == 1 && bus_oe_o == 0 && bus_o == 0, "R1",
            {sync_o, eoc_o, bus_oe_o}, 3'b010);
        mon_en = 1'b1;

        // R5: run has no effect in externally framed mode
        mode = 1'b0;
        run = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            chk(sync_o == 0 && eoc_o == 1, "R5", {sync_o, eoc_o}, 2'b01);
        end
        run = 1'b0;

        // R2/R3: externally framed lines of random length
        for (int ln = 0; ln < 10; ln++) begin
            sync_in = 1'b1;
            tick();
            chk(eoc_o == 0, "R2", eoc_o, 0);
            repeat (5 + ($urandom % 36)) tick();
            sync_in = 1'b0;
            repeat (8) tick();
            chk(eoc_o == 1, "R3", eoc_o, 1);
            snap = 0;
            for (int i = 0; i < 12; i++) begin
                tick();
                if (!eoc_o) snap++;
            end
            chk(snap == 0, "R3", snap, 0);
        end

        // R4: rising edge during drain/gap is ignored
        sync_in = 1'b1;
        repeat (6) tick();
        sync_in = 1'b0;
        tick();
        sync_in = 1'b1;
        repeat (5) tick();
        snap = 0;
        for (int i = 0; i < 25; i++) begin
            tick();
            if (!eoc_o) snap++;
        end
        chk(snap == 0, "R4", snap, 0);
        sync_in = 1'b0;
        repeat (20) tick();
        sync_in = 1'b1;
        tick();
        chk(eoc_o == 0, "R4", eoc_o, 0);
        repeat (9) tick();
        sync_in = 1'b0;
        repeat (25) tick();

        // self-framed mode
        mode = 1'b1;
        repeat (3) tick();

        // R6/R7: run pulses for one cycle, line finishes by itself
        for (int ep = 0; ep < 6; ep++) begin
            ppl = (ep == 0) ? '0 : CNT_W'($urandom % 11);
            run = 1'b1;
            tick();
            chk(sync_o == 1, "R6", sync_o, 1);
            run = 1'b0;
            ppl = CNT_W'($urandom % 11);
            guard = 0;
            while (sync_o && guard < 200) begin tick(); guard++; end
            snap = lines_done;
            repeat (30) tick();
            chk(lines_done == snap && sync_o == 0, "R7", lines_done, snap);
        end

        // R8/R6/R7: run held high for several lines, then dropped mid-line
        for (int ep = 0; ep < 6; ep++) begin
            ppl = CNT_W'($urandom % 11);
            run = 1'b1;
            snap = lines_done;
            guard = 0;
            while (lines_done < snap + 3 && guard < 2000) begin
                tick();
                guard++;
                if (($urandom % 7) == 0) ppl = CNT_W'($urandom % 11);
            end
            guard = 0;
            while (!sync_o && guard < 50) begin tick(); guard++; end
            repeat ($urandom % 3) tick();
            run = 1'b0;
            guard = 0;
            while (sync_o && guard < 200) begin tick(); guard++; end
            snap = lines_done;
            repeat (30) tick();
            chk(lines_done == snap && sync_o == 0, "R7", lines_done, snap);
        end

        // R11: read request while idle
        rd_n = 1'b0;
        @(negedge clk);
        chk(bus_oe_o == 0 && bus_o == 0, "R11", bus_oe_o, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule